// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

This block serves one endpoint direction of a packet controller. Software builds a ring of 16-byte transfer descriptors in memory and hands each one to the engine by setting its hardware-owned flag. It then writes a start address and issues a start command. The engine reads each descriptor one word per cycle. For an owned descriptor it asks an external data mover to transfer the buffer. When the mover finishes, the engine writes the actual length back, releases the descriptor to software and follows the next-pointer to the following descriptor.

When the engine finds a descriptor that software has not yet handed over, it parks there and stays active until a resume command makes it read the descriptor again. When a transfer fails, it halts with its current pointer still naming the faulting descriptor. Software can then mark that descriptor for bypass and resume, and the engine releases it without moving data. A layout input selects between a legacy descriptor layout with 16-bit length fields and an extended layout with 20-bit length fields. In the legacy layout an empty send is refused and raised as a length error.

Top module: `dring_qeng`

## Requirements
- R1: After reset the engine is inactive and not halted, and it makes no memory or transfer request.
- R2: A start command while inactive loads `cfg_start_addr` into `cur_ptr` and sets `q_active`. A start command while active changes neither `cur_ptr` nor the state.
- R3: A descriptor is word 0 flags at byte offset 0, next pointer at +4, buffer pointer at +8 and length word at +12. Flag bits are: owned bit 0, bypass bit 2, empty-packet request bit 6, completion notify bit 7. Memory accesses are one word per cycle, and read data returns one cycle after the request.
- R4: A descriptor whose owned bit is clear is not transferred. The engine stays active with `cur_ptr` on it until `cmd_resume` makes it fetch that descriptor again.
- R5: The transfer length for a send is word 3 bits 15:0 (legacy) or 19:0 (extended). For a receive it is the buffer size in word 0 bits 31:16 (legacy) or 31:12 (extended). `xfer_buf` is word 2, and `xfer_zlp` is word 0 bit 6.
- R6: On success the engine writes the actual length into the length field of word 3 and keeps the other bits of word 3. It rewrites word 0 with only the owned bit cleared, then loads `cur_ptr` from word 1.
- R7: A transfer error sets `q_halted`. `cur_ptr` stays on the faulting descriptor, and its memory words are not written.
- R8: After a resume, a descriptor with both owned and bypass set is completed without a transfer. Its owned bit is cleared, word 3 is left alone and the engine advances.
- R9: In the legacy layout, a send descriptor with length zero halts the engine as an error without issuing a transfer. In the extended layout it is transferred.
- R10: A one-cycle completion pulse is raised on `done_tx` for a send queue and on `done_rx` for a receive queue. It is raised when the completed descriptor has the notify flag or was bypassed.
- R11: A stop command lets a transfer in progress finish its write-back and advance, then clears `q_active`. A stop while parked or halted clears `q_active` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_layout | input | 1 | 1 selects the extended descriptor layout |
| q_is_tx | input | 1 | 1 for a send queue, 0 for a receive queue |
| cfg_start_addr | input | 32 | Ring start address |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_resume | input | 1 | Resume command pulse |
| q_active | output | 1 | Queue active status |
| q_halted | output | 1 | Queue halted on an error |
| cur_ptr | output | 32 | Current descriptor address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after request |
| xfer_req | output | 1 | Transfer request, held until done |
| xfer_buf | output | 32 | Buffer address for the transfer |
| xfer_len | output | 20 | Length to send or buffer size to fill |
| xfer_zlp | output | 1 | Empty-packet request for the transfer |
| xfer_done | input | 1 | Transfer finished pulse |
| xfer_err | input | 1 | Transfer failed, valid with done |
| xfer_actual | input | 20 | Bytes moved, valid with done |
| done_tx | output | 1 | Completion pulse, send queue |
| done_rx | output | 1 | Completion pulse, receive queue |

## Verification
The bench builds the engine with 32-bit addresses, a 16-bit legacy length field, a 20-bit extended length field and the extended layout enabled. This puts both layouts within reach through the layout input alone. A length above 16 bits, upper word-3 bits that must survive write-back, and the legacy-only refusal of an empty send can then be told apart within one build. Both queue directions are covered by switching the direction input between runs.

// File: rtl/dring_pkg.sv
package dring_pkg;

   localparam int unsigned DESC_WORDS = 4;
   localparam int unsigned WORD_W     = 32;

   // flag bit positions in descriptor word 0
   localparam int unsigned FL_OWN  = 0;
   localparam int unsigned FL_BYP  = 2;
   localparam int unsigned FL_ZLP  = 6;
   localparam int unsigned FL_NTFY = 7;

   // word indices inside a descriptor
   localparam int unsigned WI_FLAGS = 0;
   localparam int unsigned WI_NEXT  = 1;
   localparam int unsigned WI_BUF   = 2;
   localparam int unsigned WI_LEN   = 3;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FETCH,
      ST_EVAL,
      ST_XFER,
      ST_WB_LEN,
      ST_WB_FLG,
      ST_NEXT,
      ST_PARK,
      ST_HALT
   } walk_st_e;

endpackage

// File: rtl/dring_layout.sv
module dring_layout #(
   parameter int unsigned LEG_W   = 16,
   parameter int unsigned EXT_W   = 20,
   parameter bit          HAS_EXT = 1'b1
) (
   input  logic             ext_layout,
   input  logic             is_tx,
   input  logic [EXT_W-1:0] w0_top,
   input  logic [31:0]      w3,
   input  logic [EXT_W-1:0] actual,
   output logic [EXT_W-1:0] xfer_len,
   output logic             len_blocked,
   output logic [31:0]      w3_merged
);

   logic use_ext;

   if (LEG_W < 1 || LEG_W > EXT_W) begin : g_bad_leg
      $error("dring_layout: LEG_W must be in 1..EXT_W");
   end
   if (EXT_W > 24) begin : g_bad_ext
      $error("dring_layout: EXT_W may not reach the flag byte");
   end

   if (HAS_EXT) begin : g_ext
      assign use_ext = ext_layout;
   end else begin : g_leg_only
      assign use_ext = 1'b0;
   end

   logic [EXT_W-1:0] tx_len;
   logic [EXT_W-1:0] rx_size;

   always_comb begin
      if (use_ext) begin
         tx_len    = w3[EXT_W-1:0];
         rx_size   = w0_top;
         w3_merged = {w3[31:EXT_W], actual};
      end else begin
         tx_len    = EXT_W'(w3[LEG_W-1:0]);
         rx_size   = EXT_W'(w0_top[EXT_W-1 -: LEG_W]);
         w3_merged = {w3[31:LEG_W], actual[LEG_W-1:0]};
      end
      xfer_len    = is_tx ? tx_len : rx_size;
      len_blocked = is_tx && !use_ext && (w3[LEG_W-1:0] == '0);
   end

endmodule

// File: rtl/dring_walker.sv
module dring_walker
   import dring_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_start_addr,
   input  logic              cmd_start,
   input  logic              cmd_stop,
   input  logic              cmd_resume,
   output logic              q_active,
   output logic              q_halted,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              xfer_req,
   output logic [31:0]       xfer_buf,
   output logic              xfer_zlp,
   input  logic              xfer_done,
   input  logic              xfer_err,
   input  logic [LEN_W-1:0]  xfer_actual,
   output logic              done_pulse,
   output logic [31:0]       desc_w0,
   output logic [31:0]       desc_w3,
   output logic [LEN_W-1:0]  act_len,
   input  logic              len_blocked,
   input  logic [31:0]       w3_merged
);

   localparam int unsigned IDX_W    = $clog2(DESC_WORDS + 1);
   localparam logic [31:0] OWN_MASK = 32'(1) << FL_OWN;

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
      $error("dring_walker: ADDR_W must be in 8..32");
   end

   walk_st_e           st;
   logic [IDX_W-1:0]   rd_idx;
   logic [31:0]        dw [DESC_WORDS];
   logic               stop_pend;

   assign desc_w0 = dw[WI_FLAGS];
   assign desc_w3 = dw[WI_LEN];
   assign xfer_buf = dw[WI_BUF];
   assign xfer_zlp = dw[WI_FLAGS][FL_ZLP];
   assign xfer_req = (st == ST_XFER);
   assign done_pulse = (st == ST_NEXT) &&
                       (dw[WI_FLAGS][FL_NTFY] || dw[WI_FLAGS][FL_BYP]);

   // memory port
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_ptr;
      mem_wdata = '0;
      unique case (st)
         ST_FETCH: begin
            if (rd_idx < IDX_W'(DESC_WORDS)) begin
               mem_req  = 1'b1;
               mem_addr = cur_ptr + ADDR_W'({rd_idx, 2'b00});
            end
         end
         ST_WB_LEN: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_ptr + ADDR_W'(WI_LEN * 4);
            mem_wdata = w3_merged;
         end
         ST_WB_FLG: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = dw[WI_FLAGS] & ~OWN_MASK;
         end
         default: ;
      endcase
   end

   // word capture, one cycle after each read
   for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_cap
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dw[gi] <= '0;
         end else if (st == ST_FETCH && rd_idx == IDX_W'(gi + 1)) begin
            dw[gi] <= mem_rdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         rd_idx    <= '0;
         cur_ptr   <= '0;
         q_active  <= 1'b0;
         q_halted  <= 1'b0;
         stop_pend <= 1'b0;
         act_len   <= '0;
      end else begin
         if (cmd_stop && q_active) begin
            stop_pend <= 1'b1;
         end
         unique case (st)
            ST_IDLE: begin
               stop_pend <= 1'b0;
               if (cmd_start) begin
                  cur_ptr  <= cfg_start_addr;
                  q_active <= 1'b1;
                  rd_idx   <= '0;
                  st       <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (rd_idx == IDX_W'(DESC_WORDS)) begin
                  rd_idx <= '0;
                  st     <= ST_EVAL;
               end else begin
                  rd_idx <= rd_idx + 1'b1;
               end
            end
            ST_EVAL: begin
               if (!dw[WI_FLAGS][FL_OWN]) begin
                  st <= ST_PARK;
               end else if (dw[WI_FLAGS][FL_BYP]) begin
                  st <= ST_WB_FLG;
               end else if (len_blocked) begin
                  q_halted <= 1'b1;
                  st       <= ST_HALT;
               end else begin
                  st <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (xfer_done) begin
                  if (xfer_err) begin
                     q_halted <= 1'b1;
                     st       <= ST_HALT;
                  end else begin
                     act_len <= xfer_actual;
                     st      <= ST_WB_LEN;
                  end
               end
            end
            ST_WB_LEN: st <= ST_WB_FLG;
            ST_WB_FLG: st <= ST_NEXT;
            ST_NEXT: begin
               cur_ptr <= dw[WI_NEXT][ADDR_W-1:0];
               if (stop_pend || cmd_stop) begin
                  q_active  <= 1'b0;
                  stop_pend <= 1'b0;
                  st        <= ST_IDLE;
               end else begin
                  st <= ST_FETCH;
               end
            end
            ST_PARK, ST_HALT: begin
               if (stop_pend || cmd_stop) begin
                  q_active  <= 1'b0;
                  q_halted  <= 1'b0;
                  stop_pend <= 1'b0;
                  st        <= ST_IDLE;
               end else if (cmd_resume) begin
                  q_halted <= 1'b0;
                  rd_idx   <= '0;
                  st       <= ST_FETCH;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R2: start while active leaves the pointer alone
   a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      q_active && cmd_start && st != ST_NEXT |=> cur_ptr == $past(cur_ptr));

   // R4: only an owned, non-bypassed descriptor reaches the mover
   a_r4_owned_only: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> dw[WI_FLAGS][FL_OWN] && !dw[WI_FLAGS][FL_BYP]);

   // R6: a good completion is followed by a write to memory
   a_r6_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && xfer_done && !xfer_err |=> mem_req && mem_we);

   // R7: halted implies the queue is still active
   a_r7_halt_active: assert property (@(posedge clk) disable iff (!rst_n)
      q_halted |-> q_active);

   // R11: a request in flight is held until its done
   a_r11_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_done |=> xfer_req);

   // R11: stop while parked or halted takes effect at once
   a_r11_park_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PARK || st == ST_HALT) && cmd_stop |=> !q_active);

   // R3: a write is always a request
   a_r3_we_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

endmodule

// File: rtl/dring_qeng.sv
module dring_qeng #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned LEG_W   = 16,
   parameter int unsigned EXT_W   = 20,
   parameter bit          HAS_EXT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_layout,
   input  logic              q_is_tx,
   input  logic [ADDR_W-1:0] cfg_start_addr,
   input  logic              cmd_start,
   input  logic              cmd_stop,
   input  logic              cmd_resume,
   output logic              q_active,
   output logic              q_halted,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              xfer_req,
   output logic [31:0]       xfer_buf,
   output logic [EXT_W-1:0]  xfer_len,
   output logic              xfer_zlp,
   input  logic              xfer_done,
   input  logic              xfer_err,
   input  logic [EXT_W-1:0]  xfer_actual,
   output logic              done_tx,
   output logic              done_rx
);

   logic              done_pulse;
   logic [31:0]       desc_w0;
   logic [31:0]       desc_w3;
   logic [EXT_W-1:0]  act_len;
   logic              len_blocked;
   logic [31:0]       w3_merged;

   dring_walker #(
      .ADDR_W (ADDR_W),
      .LEN_W  (EXT_W)
   ) u_walk (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_start_addr (cfg_start_addr),
      .cmd_start      (cmd_start),
      .cmd_stop       (cmd_stop),
      .cmd_resume     (cmd_resume),
      .q_active       (q_active),
      .q_halted       (q_halted),
      .cur_ptr        (cur_ptr),
      .mem_req        (mem_req),
      .mem_we         (mem_we),
      .mem_addr       (mem_addr),
      .mem_wdata      (mem_wdata),
      .mem_rdata      (mem_rdata),
      .xfer_req       (xfer_req),
      .xfer_buf       (xfer_buf),
      .xfer_zlp       (xfer_zlp),
      .xfer_done      (xfer_done),
      .xfer_err       (xfer_err),
      .xfer_actual    (xfer_actual),
      .done_pulse     (done_pulse),
      .desc_w0        (desc_w0),
      .desc_w3        (desc_w3),
      .act_len        (act_len),
      .len_blocked    (len_blocked),
      .w3_merged      (w3_merged)
   );

   dring_layout #(
      .LEG_W   (LEG_W),
      .EXT_W   (EXT_W),
      .HAS_EXT (HAS_EXT)
   ) u_lay (
      .ext_layout  (ext_layout),
      .is_tx       (q_is_tx),
      .w0_top      (desc_w0[31 -: EXT_W]),
      .w3          (desc_w3),
      .actual      (act_len),
      .xfer_len    (xfer_len),
      .len_blocked (len_blocked),
      .w3_merged   (w3_merged)
   );

   assign done_tx = done_pulse && q_is_tx;
   assign done_rx = done_pulse && !q_is_tx;

   // R9: legacy empty sends never reach the mover
   a_r9_no_empty_send: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && q_is_tx && !(HAS_EXT && ext_layout) |-> xfer_len != '0);

   // R10: the two completion pulses never coincide
   a_r10_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_tx, done_rx}));

   // R1: nothing is requested while inactive
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !q_active |-> !xfer_req && !mem_req);

endmodule

// File: tb/sim_dring_qeng.sv
module sim_dring_qeng;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_layout = 1'b0;
   logic        q_is_tx = 1'b1;
   logic [31:0] cfg_start_addr = '0;
   logic        cmd_start = 1'b0, cmd_stop = 1'b0, cmd_resume = 1'b0;
   logic        q_active, q_halted;
   logic [31:0] cur_ptr;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata;
   logic        xfer_req;
   logic [31:0] xfer_buf;
   logic [19:0] xfer_len;
   logic        xfer_zlp;
   logic        xfer_done, xfer_err;
   logic [19:0] xfer_actual;
   logic        done_tx, done_rx;

   always #4 clk = ~clk;

   dring_qeng u0 (
      .clk(clk), .rst_n(rst_n), .ext_layout(ext_layout), .q_is_tx(q_is_tx),
      .cfg_start_addr(cfg_start_addr), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
      .cmd_resume(cmd_resume), .q_active(q_active), .q_halted(q_halted),
      .cur_ptr(cur_ptr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .xfer_req(xfer_req),
      .xfer_buf(xfer_buf), .xfer_len(xfer_len), .xfer_zlp(xfer_zlp),
      .xfer_done(xfer_done), .xfer_err(xfer_err), .xfer_actual(xfer_actual),
      .done_tx(done_tx), .done_rx(done_rx)
   );

   // memory model, one-cycle read latency
   logic [31:0] mem [256];
   logic        tb_we = 1'b0;
   logic [31:0] tb_a = '0, tb_d = '0;
   always @(posedge clk) begin
      if (tb_we) mem[tb_a[9:2]] <= tb_d;
      else if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[9:2]];
   end

   // data mover model
   logic        mv_err = 1'b0, mv_ovr = 1'b0;
   logic [19:0] mv_act = '0;
   int          mv_cnt;
   always @(posedge clk) begin
      if (!rst_n) begin
         xfer_done <= 1'b0; xfer_err <= 1'b0; xfer_actual <= '0; mv_cnt <= 0;
      end else if (xfer_req && !xfer_done) begin
         if (mv_cnt == 2) begin
            xfer_done   <= 1'b1;
            xfer_err    <= mv_err;
            xfer_actual <= mv_ovr ? mv_act : xfer_len;
            mv_cnt      <= 0;
         end else mv_cnt <= mv_cnt + 1;
      end else xfer_done <= 1'b0;
   end

   // observers
   int          xfer_cnt = 0, done_cnt = 0;
   logic        req_d = 1'b0, last_dir_tx = 1'b0;
   logic [19:0] rec_len = '0;
   logic [31:0] rec_buf = '0;
   logic        rec_zlp = 1'b0;
   always @(posedge clk) begin
      req_d <= xfer_req;
      if (xfer_req && !req_d) begin
         xfer_cnt <= xfer_cnt + 1;
         rec_len  <= xfer_len;
         rec_buf  <= xfer_buf;
         rec_zlp  <= xfer_zlp;
      end
      if (done_tx || done_rx) begin
         done_cnt    <= done_cnt + 1;
         last_dir_tx <= done_tx;
      end
   end

   int n_chk = 0, n_err = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk); tb_we = 1'b1; tb_a = a; tb_d = d;
      @(negedge clk); tb_we = 1'b0;
   endtask

   task automatic mk_desc(input logic [31:0] base, input logic [31:0] w0,
                          input logic [31:0] nxt, input logic [31:0] buff,
                          input logic [31:0] w3);
      poke(base, w0); poke(base + 4, nxt); poke(base + 8, buff); poke(base + 12, w3);
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem[a[9:2]];
   endfunction

   task automatic pulse_start(input logic [31:0] a);
      @(negedge clk); cfg_start_addr = a; cmd_start = 1'b1;
      @(negedge clk); cmd_start = 1'b0;
   endtask
   task automatic pulse_stop();
      @(negedge clk); cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
   endtask
   task automatic pulse_resume();
      @(negedge clk); cmd_resume = 1'b1; @(negedge clk); cmd_resume = 1'b0;
   endtask
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 active", 32'(q_active), 0);
      chk("R1 halted", 32'(q_halted), 0);
      chk("R1 requests", 32'({mem_req, xfer_req}), 0);
   endtask

   task automatic t_tx_ring();
      int x0, d0;
      q_is_tx = 1'b1; ext_layout = 1'b0; mv_ovr = 1'b0;
      mk_desc(32'h100, 32'h81, 32'h110, 32'hA000, 32'hABC0_0040);
      mk_desc(32'h110, 32'h01, 32'h120, 32'hA100, 32'h0000_0010);
      mk_desc(32'h120, 32'h80, 32'h100, 32'hA200, 32'h0000_0020);
      x0 = xfer_cnt; d0 = done_cnt;
      pulse_start(32'h100);
      idle(80);
      chk("R6 w3 keeps upper bits", rd(32'h10C), 32'hABC0_0040);
      chk("R6 owned cleared d0", rd(32'h100), 32'h80);
      chk("R6 owned cleared d1", rd(32'h110), 32'h00);
      chk("R4 parked ptr", cur_ptr, 32'h120);
      chk("R4 still active", 32'(q_active), 1);
      chk("R4 two transfers", 32'(xfer_cnt - x0), 2);
      chk("R10 notify gating", 32'(done_cnt - d0), 1);
      chk("R10 dir tag tx", 32'(last_dir_tx), 1);
      chk("R5 last tx len", 32'(rec_len), 32'h10);
      chk("R3 buffer ptr", rec_buf, 32'hA100);
      pulse_start(32'h180);
      idle(5);
      chk("R2 start while active", cur_ptr, 32'h120);
      d0 = done_cnt;
      poke(32'h120, 32'h81);
      pulse_resume();
      idle(80);
      chk("R4 resume refetch wraps", cur_ptr, 32'h100);
      chk("R6 w3 d2", rd(32'h12C), 32'h20);
      chk("R10 done after resume", 32'(done_cnt - d0), 1);
      pulse_stop();
      idle(2);
      chk("R11 stop while parked", 32'(q_active), 0);
   endtask

   task automatic t_err_bypass();
      int x0, d0;
      mk_desc(32'h140, 32'h81, 32'h150, 32'hB000, 32'h8);
      mk_desc(32'h150, 32'h00, 32'h140, 32'hB100, 32'h8);
      mv_err = 1'b1;
      pulse_start(32'h140);
      idle(60);
      chk("R7 halted", 32'(q_halted), 1);
      chk("R7 ptr on fault", cur_ptr, 32'h140);
      chk("R7 w0 untouched", rd(32'h140), 32'h81);
      chk("R7 w3 untouched", rd(32'h14C), 32'h8);
      mv_err = 1'b0;
      poke(32'h140, 32'h05);
      x0 = xfer_cnt; d0 = done_cnt;
      pulse_resume();
      idle(60);
      chk("R8 no transfer", 32'(xfer_cnt - x0), 0);
      chk("R8 owned cleared", rd(32'h140), 32'h04);
      chk("R8 w3 left alone", rd(32'h14C), 32'h8);
      chk("R8 advanced", cur_ptr, 32'h150);
      chk("R8 halt cleared", 32'(q_halted), 0);
      chk("R10 bypass raises done", 32'(done_cnt - d0), 1);
      pulse_stop(); idle(3);
   endtask

   task automatic t_zero_len();
      int x0;
      mk_desc(32'h160, 32'h81, 32'h170, 32'hC000, 32'h0);
      mk_desc(32'h170, 32'h00, 32'h160, 32'hC100, 32'h0);
      ext_layout = 1'b0;
      x0 = xfer_cnt;
      pulse_start(32'h160);
      idle(40);
      chk("R9 legacy empty halts", 32'(q_halted), 1);
      chk("R9 legacy no transfer", 32'(xfer_cnt - x0), 0);
      chk("R9 legacy ptr", cur_ptr, 32'h160);
      pulse_stop(); idle(3);
      chk("R11 stop while halted", 32'(q_active), 0);
      ext_layout = 1'b1;
      x0 = xfer_cnt;
      pulse_start(32'h160);
      idle(60);
      chk("R9 ext empty transfers", 32'(xfer_cnt - x0), 1);
      chk("R9 ext advanced", cur_ptr, 32'h170);
      pulse_stop(); idle(3);
   endtask

   task automatic t_ext_len();
      ext_layout = 1'b1; q_is_tx = 1'b1;
      mk_desc(32'h180, 32'hC1, 32'h190, 32'hB000, 32'hF001_2345);
      mk_desc(32'h190, 32'h00, 32'h180, 32'h0, 32'h0);
      mv_ovr = 1'b1; mv_act = 20'h0ABCD;
      pulse_start(32'h180);
      idle(60);
      chk("R5 ext tx len", 32'(rec_len), 32'h12345);
      chk("R5 zlp flag", 32'(rec_zlp), 1);
      chk("R6 ext write-back", rd(32'h18C), 32'hF000_ABCD);
      pulse_stop(); idle(3);
   endtask

   task automatic t_rx();
      q_is_tx = 1'b0; ext_layout = 1'b0;
      mk_desc(32'h1A0, 32'h0200_0081, 32'h1B0, 32'hD000, 32'h1234_0000);
      mk_desc(32'h1B0, 32'h00, 32'h1C0, 32'hD100, 32'h0);
      mk_desc(32'h1C0, 32'h00, 32'h1A0, 32'h0, 32'h0);
      mv_ovr = 1'b1; mv_act = 20'h33;
      pulse_start(32'h1A0);
      idle(60);
      chk("R5 legacy rx size", 32'(rec_len), 32'h200);
      chk("R6 rx write-back", rd(32'h1AC), 32'h1234_0033);
      chk("R10 dir tag rx", 32'(last_dir_tx), 0);
      pulse_stop(); idle(3);
      ext_layout = 1'b1;
      mk_desc(32'h1B0, 32'h0300_0081, 32'h1C0, 32'hD100, 32'h0);
      pulse_start(32'h1B0);
      idle(60);
      chk("R5 ext rx size", 32'(rec_len), 32'h3000);
      chk("R6 ext rx write-back", rd(32'h1BC), 32'h33);
      pulse_stop(); idle(3);
   endtask

   task automatic t_stop_inflight();
      int x0;
      q_is_tx = 1'b1; ext_layout = 1'b0; mv_ovr = 1'b0;
      mk_desc(32'h1D0, 32'h01, 32'h1E0, 32'hE000, 32'h4);
      mk_desc(32'h1E0, 32'h01, 32'h1D0, 32'hE100, 32'h4);
      x0 = xfer_cnt;
      pulse_start(32'h1D0);
      for (int i = 0; i < 40 && !xfer_req; i++) @(negedge clk);
      pulse_stop();
      idle(30);
      chk("R11 inactive after stop", 32'(q_active), 0);
      chk("R11 advanced past in-flight", cur_ptr, 32'h1E0);
      chk("R11 one transfer", 32'(xfer_cnt - x0), 1);
      chk("R11 in-flight released", rd(32'h1D0), 32'h00);
      chk("R11 next not touched", rd(32'h1E0), 32'h01);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_tx_ring();
      t_err_bypass();
      t_zero_len();
      t_ext_len();
      t_rx();
      t_stop_inflight();
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
   end

endmodule